// File: doc/BRIEF.md
# Block-mode FIFO service controller

This block is the register-facing transfer controller that sits between a processor register bus and a serial shift engine. Software programs a word length, enables or disables each direction, loads how many bytes go out and how many come in, and then steps a core state machine between RESET, RUN and PAUSE. Every state change is gated by a VALID flag that drops while the change settles.

Data moves through two byte FIFOs. Software fills the output FIFO through a register, and the shift engine drains it over a valid/ready byte stream. The shift engine fills the input FIFO over a second valid/ready stream, and software drains it through a register. Software never polls FIFO levels byte by byte. Instead, the block raises a service request for each direction that grants a block of up to four bytes. Software clears the request by writing one to it, then moves that block. Done flags, FIFO level flags and sticky error flags complete the status view, and a masked error summary is driven on a pin.

Back-pressure: a byte leaves on `tx_*` only in a cycle where both `tx_valid` and `tx_ready` are high. A byte enters on `rx_*` only in a cycle where both `rx_valid` and `rx_ready` are high. `tx_valid` does not depend on `tx_ready`, and `rx_ready` does not depend on `rx_valid`.

Top module: `blk_svc_ctl`

## Requirements
- R1: Out of reset:
  - the core state reads RESET (0) with VALID (state register bit 2) set, so the state register reads 0x4;
  - the configuration register reads 0x07, and `word_len_m1` is 7;
  - the status register reads 0, and both transfer counts read 0.
- R2: A state write accepted while VALID is 1 has these effects:
  - VALID is cleared for two cycles.
  - The new state takes effect on the second edge after the write, and VALID returns to 1 at the same time.
  - A state write made while VALID is 0 is ignored.
  - The state codes are 0 = RESET, 1 = RUN and 3 = PAUSE. Writing 2 (clear) puts the core into RESET.
- R3: The output and input transfer counts are 16 bits wide. They can be written only while the core is in RESET; writes in RUN or PAUSE are ignored.
- R4: Output service request (status bit 8):
  - It is raised in RUN when the output path is enabled (configuration bit 6 = 0), at least 4 output FIFO slots are free, and bytes of the output count remain unwritten.
  - It grants min(4, remaining) writes. Status bit 12 stays set while granted writes are outstanding.
  - The next request comes only after the granted block has been written.
- R5: Writing 1 to status bit 8 or bit 9 clears that service request. Writing 0 to either bit has no effect.
- R6: Input service request (status bit 9):
  - It is raised in RUN when the input path is enabled (configuration bit 7 = 0) and the input FIFO holds either at least 4 bytes or every byte still owed to software.
  - It grants min(4, owed) reads. Status bit 13 stays set while granted reads are outstanding.
- R7: Output stream:
  - `tx_valid` is high only in RUN, with the output path enabled, the output FIFO non-empty, and fewer bytes sent than the output count.
  - Bytes leave in FIFO order.
  - Status bit 10 (output done) is set once the sent count equals a non-zero output count.
- R8: Input stream:
  - `rx_ready` is high only in RUN, with the input path enabled, the input FIFO not full, and fewer bytes received than the input count.
  - Software reads bytes back in arrival order.
  - Status bit 11 (input done) is set once the received count equals a non-zero input count.
- R9: FIFO level flags in the status register:
  - bit 4 = output FIFO not empty, bit 5 = input FIFO not empty;
  - bit 6 = output FIFO full, bit 7 = input FIFO full.
- R10: Error flags (error register):
  - Each is sticky until written with 1 (write-one-to-clear).
  - bit 5 = output overrun: a write to the full output FIFO; the byte is dropped.
  - bit 4 = input underrun: a read of the empty input FIFO, which returns 0.
  - bit 3 = output underrun: in RUN, `tx_ready` is high with the output FIFO empty while bytes are still owed.
  - bit 2 = input overrun: in RUN, `rx_valid` is high with the input FIFO full while bytes are still owed.
  - `err_irq` is the OR of the error flags ANDed with the error enable register, which uses the same bit positions.
- R11: Entering RESET (by writing 0 or 2) empties both FIFOs and clears the service, grant and done flags.
- R12: Writing 1 to bit 0 of the software reset register returns every register to its R1 value at the next edge.
- R13: In PAUSE, both streams stop, no new service requests are raised, and FIFO contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data one cycle later) |
| reg_addr | input | 4 | Register word index: 0 config, 1 state, 2 status, 3 software reset, 4 output count, 5 input count, 6 output FIFO, 7 input FIFO, 8 errors, 9 error enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered on the read edge |
| tx_valid | output | 1 | Output byte available to the shift engine |
| tx_ready | input | 1 | Shift engine accepts the output byte |
| tx_data | output | 8 | Output byte |
| rx_valid | input | 1 | Shift engine offers a received byte |
| rx_ready | output | 1 | Block accepts the received byte |
| rx_data | input | 8 | Received byte |
| word_len_m1 | output | 5 | Word length minus one, passed to the shift engine |
| err_irq | output | 1 | Enabled error summary |

## Verification
Register reads are captured on the edge of the read cycle. The bench therefore samples `reg_rdata` at the falling edge that follows, and its view of status is the state before that edge.

A state write settles over two edges. The bench issues reads on the first, second and third edges after the write and expects VALID to be 0, 0 and 1 respectively. Service requests appear one edge after their condition holds, so the bench adds one idle cycle before reading status after a FIFO push or pop.

The stream pins are combinational from block state. The bench samples `tx_valid`, `tx_data` and `rx_ready` at falling edges, and counts a transfer at the following rising edge.

// File: rtl/blk_svc_pkg.sv
package blk_svc_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } core_state_e;

  localparam int BLK_BYTES = 4;
  localparam int BLK_CW    = $clog2(BLK_BYTES + 1);

  localparam logic [3:0] A_CFG   = 4'd0;
  localparam logic [3:0] A_STATE = 4'd1;
  localparam logic [3:0] A_OP    = 4'd2;
  localparam logic [3:0] A_SWRST = 4'd3;
  localparam logic [3:0] A_OCNT  = 4'd4;
  localparam logic [3:0] A_ICNT  = 4'd5;
  localparam logic [3:0] A_OFIFO = 4'd6;
  localparam logic [3:0] A_IFIFO = 4'd7;
  localparam logic [3:0] A_ERR   = 4'd8;
  localparam logic [3:0] A_ERREN = 4'd9;

  localparam int B_OUT_SVC = 8;
  localparam int B_IN_SVC  = 9;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    full && push && !pop |=> full); // R10
endmodule

// File: rtl/core_state_ctl.sv
module core_state_ctl
  import blk_svc_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [1:0]  wr_state,
  output core_state_e state,
  output logic        valid,
  output logic        enter_reset
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] settle_q;
  core_state_e   pend_q;

  assign valid       = (settle_q == '0);
  assign enter_reset = (settle_q == SW'(1)) &&
                       (pend_q == ST_RESET || pend_q == ST_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RESET; pend_q <= ST_RESET; settle_q <= '0;
    end else if (clr) begin
      state <= ST_RESET; pend_q <= ST_RESET; settle_q <= '0;
    end else if (wr_en && valid) begin
      pend_q   <= core_state_e'(wr_state);
      settle_q <= SW'(SETTLE);
    end else if (settle_q != '0) begin
      settle_q <= settle_q - 1'b1;
      if (settle_q == SW'(1))
        state <= (pend_q == ST_CLEAR) ? ST_RESET : pend_q;
    end
  end

  AST_VALID_SETTLE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    wr_en && valid |=> !valid ##1 !valid ##1 valid); // R2
  AST_STATE_STEADY: assert property (@(posedge clk) disable iff (!rst_n || clr)
    valid && !wr_en |=> $stable(state)); // R2
  AST_NO_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_CLEAR); // R2
endmodule

// File: rtl/svc_gate.sv
module svc_gate
  import blk_svc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              eligible,
  input  logic [BLK_CW-1:0] grant_size,
  input  logic              consume,
  input  logic              ack,
  output logic              svc,
  output logic              blk_open
);
  logic [BLK_CW-1:0] grant_q;
  logic              raise;

  assign raise    = run && eligible && (grant_q == '0);
  assign blk_open = (grant_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc <= 1'b0; grant_q <= '0;
    end else if (clr) begin
      svc <= 1'b0; grant_q <= '0;
    end else if (raise) begin
      svc     <= 1'b1;
      grant_q <= grant_size;
    end else begin
      if (ack) svc <= 1'b0;
      if (consume && grant_q != '0) grant_q <= grant_q - 1'b1;
    end
  end

  AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q <= BLK_CW'(BLK_BYTES)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack && grant_q != '0 |=> !svc); // R5
  AST_NO_RAISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !svc && !clr |=> !svc); // R13
endmodule

// File: rtl/blk_svc_ctl.sv
module blk_svc_ctl
  import blk_svc_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic [4:0]        word_len_m1,
  output logic              err_irq
);
  localparam int FW = $clog2(FIFO_DEPTH + 1);
  localparam int DIR_OUT = 0;
  localparam int DIR_IN  = 1;

  // configuration and counts
  logic             no_out_q, no_in_q;
  logic [4:0]       wlen_q;
  logic [CNT_W-1:0] ocnt_q, icnt_q;
  logic [CNT_W-1:0] o_pushed_q, o_sent_q, i_recv_q, i_popped_q;
  logic [5:2]       err_q, err_en_q;

  core_state_e state;
  logic        st_valid, enter_reset, run, flush, sw_clr;

  logic        of_push, of_full, of_empty, if_pop, if_full, if_empty;
  logic [FW-1:0] of_count, if_count;
  logic [7:0]  if_dout;
  logic        tx_fire, rx_fire, of_acc, if_acc;

  logic [1:0]              elig, consume, ack, svc, blk_open;
  logic [BLK_CW-1:0]       gsize [2];
  logic [CNT_W-1:0]        wr_left, rd_left;
  logic [5:2]              err_set, err_w1c;
  logic [DATA_W-1:0]       op_word, rd_mux;

  function automatic logic wr_at(input logic [3:0] a);
    return reg_wr && (reg_addr == ADDR_W'(a));
  endfunction

  assign sw_clr = wr_at(A_SWRST) && reg_wdata[0];
  assign run    = (state == ST_RUN);
  assign flush  = enter_reset || sw_clr;

  core_state_ctl #(.SETTLE(2)) u_state (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr),
    .wr_en(wr_at(A_STATE)), .wr_state(reg_wdata[1:0]),
    .state(state), .valid(st_valid), .enter_reset(enter_reset)
  );

  // stream side
  assign tx_valid = run && !no_out_q && !of_empty && (o_sent_q < ocnt_q);
  assign rx_ready = run && !no_in_q && !if_full && (i_recv_q < icnt_q);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_valid && rx_ready;

  // register side FIFO access
  assign of_push = wr_at(A_OFIFO);
  assign if_pop  = reg_rd && (reg_addr == ADDR_W'(A_IFIFO));
  assign of_acc  = of_push && !of_full;
  assign if_acc  = if_pop && !if_empty;

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_ofifo (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(of_push), .din(reg_wdata[7:0]), .pop(tx_fire), .dout(tx_data),
    .count(of_count), .full(of_full), .empty(of_empty)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_ififo (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(rx_fire), .din(rx_data), .pop(if_pop), .dout(if_dout),
    .count(if_count), .full(if_full), .empty(if_empty)
  );

  // service eligibility per direction
  assign wr_left = (ocnt_q > o_pushed_q) ? ocnt_q - o_pushed_q : '0;
  assign rd_left = icnt_q - i_popped_q;

  assign elig[DIR_OUT] = !no_out_q && (wr_left != '0) &&
                         ((FW'(FIFO_DEPTH) - of_count) >= FW'(BLK_BYTES));
  assign elig[DIR_IN]  = !no_in_q && (if_count != '0) &&
                         ((if_count >= FW'(BLK_BYTES)) || (CNT_W'(if_count) == rd_left));
  assign gsize[DIR_OUT] = (wr_left >= CNT_W'(BLK_BYTES)) ? BLK_CW'(BLK_BYTES)
                                                          : wr_left[BLK_CW-1:0];
  assign gsize[DIR_IN]  = (rd_left >= CNT_W'(BLK_BYTES)) ? BLK_CW'(BLK_BYTES)
                                                          : rd_left[BLK_CW-1:0];
  assign consume[DIR_OUT] = of_acc;
  assign consume[DIR_IN]  = if_acc;
  assign ack[DIR_OUT] = wr_at(A_OP) && reg_wdata[B_OUT_SVC];
  assign ack[DIR_IN]  = wr_at(A_OP) && reg_wdata[B_IN_SVC];

  for (genvar d = 0; d < 2; d++) begin : g_svc
    svc_gate u_gate (
      .clk(clk), .rst_n(rst_n), .clr(flush), .run(run),
      .eligible(elig[d]), .grant_size(gsize[d]), .consume(consume[d]),
      .ack(ack[d]), .svc(svc[d]), .blk_open(blk_open[d])
    );
  end

  // configuration, counts and progress counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      no_out_q <= 1'b0; no_in_q <= 1'b0; wlen_q <= 5'd7;
      ocnt_q <= '0; icnt_q <= '0; err_en_q <= '0;
    end else if (sw_clr) begin
      no_out_q <= 1'b0; no_in_q <= 1'b0; wlen_q <= 5'd7;
      ocnt_q <= '0; icnt_q <= '0; err_en_q <= '0;
    end else begin
      if (wr_at(A_CFG)) begin
        no_out_q <= reg_wdata[6];
        no_in_q  <= reg_wdata[7];
        wlen_q   <= reg_wdata[4:0];
      end
      if (wr_at(A_OCNT) && state == ST_RESET) ocnt_q <= reg_wdata[CNT_W-1:0];
      if (wr_at(A_ICNT) && state == ST_RESET) icnt_q <= reg_wdata[CNT_W-1:0];
      if (wr_at(A_ERREN)) err_en_q <= reg_wdata[5:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_pushed_q <= '0; o_sent_q <= '0; i_recv_q <= '0; i_popped_q <= '0;
    end else if (flush) begin
      o_pushed_q <= '0; o_sent_q <= '0; i_recv_q <= '0; i_popped_q <= '0;
    end else begin
      if (of_acc && o_pushed_q != '1) o_pushed_q <= o_pushed_q + 1'b1;
      if (tx_fire) o_sent_q   <= o_sent_q + 1'b1;
      if (rx_fire) i_recv_q   <= i_recv_q + 1'b1;
      if (if_acc)  i_popped_q <= i_popped_q + 1'b1;
    end
  end

  // sticky errors, set wins over clear
  assign err_set[5] = of_push && of_full;
  assign err_set[4] = if_pop && if_empty;
  assign err_set[3] = run && !no_out_q && tx_ready && of_empty && (o_sent_q < ocnt_q);
  assign err_set[2] = run && !no_in_q && rx_valid && if_full && (i_recv_q < icnt_q);
  assign err_w1c    = wr_at(A_ERR) ? reg_wdata[5:2] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (sw_clr) err_q <= '0;
    else             err_q <= (err_q & ~err_w1c) | err_set;
  end

  assign err_irq     = |(err_q & err_en_q);
  assign word_len_m1 = wlen_q;

  // status word and read path
  always_comb begin
    op_word     = '0;
    op_word[4]  = !of_empty;
    op_word[5]  = !if_empty;
    op_word[6]  = of_full;
    op_word[7]  = if_full;
    op_word[8]  = svc[DIR_OUT];
    op_word[9]  = svc[DIR_IN];
    op_word[10] = (ocnt_q != '0) && (o_sent_q == ocnt_q);
    op_word[11] = (icnt_q != '0) && (i_recv_q == icnt_q);
    op_word[12] = blk_open[DIR_OUT];
    op_word[13] = blk_open[DIR_IN];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(A_CFG):   rd_mux = DATA_W'({no_in_q, no_out_q, 1'b0, wlen_q});
      ADDR_W'(A_STATE): rd_mux = DATA_W'({st_valid, state});
      ADDR_W'(A_OP):    rd_mux = op_word;
      ADDR_W'(A_OCNT):  rd_mux = DATA_W'(ocnt_q);
      ADDR_W'(A_ICNT):  rd_mux = DATA_W'(icnt_q);
      ADDR_W'(A_IFIFO): rd_mux = if_empty ? '0 : DATA_W'(if_dout);
      ADDR_W'(A_ERR):   rd_mux = DATA_W'({err_q, 2'b00});
      ADDR_W'(A_ERREN): rd_mux = DATA_W'({err_en_q, 2'b00});
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_SENT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    o_sent_q <= ocnt_q); // R7
  AST_RECV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    i_recv_q <= icnt_q); // R8
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_RESET && !sw_clr |=> $stable(ocnt_q) && $stable(icnt_q)); // R3
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enter_reset |=> !tx_valid && !rx_ready && svc == 2'b00); // R11
  AST_PAUSE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PAUSE |-> !tx_fire && !rx_fire); // R13
endmodule

// File: tb/blk_svc_ctl_tb_top.sv
`timescale 1ns/1ps
module blk_svc_ctl_tb_top;
  localparam logic [3:0] R_CFG = 0, R_ST = 1, R_OP = 2, R_SWR = 3, R_OC = 4,
                         R_IC = 5, R_OF = 6, R_IF = 7, R_ER = 8, R_EE = 9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic [7:0]  tx_data, rx_data = '0;
  logic [4:0]  word_len_m1;
  logic        err_irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] cap [8];
  int cap_n;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  blk_svc_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .word_len_m1(word_len_m1), .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic set_state(input logic [1:0] s);
    wr(R_ST, {30'b0, s});
    repeat (3) @(negedge clk);
  endtask

  task automatic collect(input int n);
    tx_ready = 1'b1; cap_n = 0;
    for (int k = 0; k < 40 && cap_n < n; k++) begin
      if (tx_valid) begin cap[cap_n] = tx_data; cap_n++; end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R7 captured count", 32'(cap_n), 32'(n));
  endtask

  task automatic t_reset;
    rd(R_ST, v);  chk("R1 state", v, 32'h4);
    rd(R_CFG, v); chk("R1 cfg", v, 32'h07);
    rd(R_OP, v);  chk("R1 status", v, 32'h0);
    rd(R_OC, v);  chk("R1 out count", v, 32'h0);
    chk("R1 word_len_m1", 32'(word_len_m1), 32'd7);
  endtask

  task automatic t_state;
    wr(R_ST, 32'h1);
    wr(R_ST, 32'h3);                       // ignored, VALID low
    rd(R_ST, v); chk("R2 settling", v, 32'h0);
    rd(R_ST, v); chk("R2 settled run", v, 32'h5);
    set_state(2'd3);
    rd(R_ST, v); chk("R2 pause", v, 32'h7);
    set_state(2'd2);
    rd(R_ST, v); chk("R2 clear->reset", v, 32'h4);
  endtask

  task automatic t_counts;
    wr(R_OC, 32'h6);       rd(R_OC, v); chk("R3 load out count", v, 32'h6);
    wr(R_IC, 32'h1FFFF);   rd(R_IC, v); chk("R3 16-bit count", v, 32'hFFFF);
    set_state(2'd1);
    wr(R_OC, 32'h9);       rd(R_OC, v); chk("R3 count frozen in run", v, 32'h6);
    set_state(2'd0);
  endtask

  task automatic t_tx;
    wr(R_SWR, 1); wr(R_CFG, 32'h87); wr(R_OC, 6);
    set_state(2'd1);
    rd(R_OP, v); chk("R4 out request", v, 32'h1100);
    wr(R_OP, 32'h0);   rd(R_OP, v); chk("R5 write 0 no effect", v, 32'h1100);
    wr(R_OP, 32'h100); rd(R_OP, v); chk("R5 ack clears", v, 32'h1000);
    for (int i = 0; i < 4; i++) wr(R_OF, 32'hA1 + i);
    @(negedge clk);
    rd(R_OP, v); chk("R4 second block of 2", v, 32'h1110);
    wr(R_OF, 32'hA5); wr(R_OF, 32'hA6); wr(R_OP, 32'h100);
    @(negedge clk);
    rd(R_OP, v); chk("R4 no request when count used", v, 32'h0010);
    collect(6);
    for (int i = 0; i < 6; i++) chk("R7 tx order", 32'(cap[i]), 32'hA1 + i);
    chk("R7 tx idle after count", 32'(tx_valid), 0);
    rd(R_OP, v); chk("R7 out done", v, 32'h0400);
  endtask

  task automatic t_rx;
    wr(R_SWR, 1); wr(R_CFG, 32'h47); wr(R_IC, 5);
    chk("R8 no rx in reset", 32'(rx_ready), 0);
    set_state(2'd1);
    chk("R8 rx ready in run", 32'(rx_ready), 1);
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1'b1; rx_data = 8'h30 + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk("R8 rx closed at count", 32'(rx_ready), 0);
    rd(R_OP, v); chk("R6 in request", v, 32'h2A20);
    wr(R_OP, 32'h200);
    for (int i = 0; i < 4; i++) begin
      rd(R_IF, v); chk("R8 rx order", v, 32'h30 + i);
    end
    @(negedge clk);
    rd(R_OP, v); chk("R6 request for last byte", v, 32'h2A20);
    rd(R_IF, v); chk("R8 last byte", v, 32'h34);
    rd(R_IF, v); chk("R10 empty read returns 0", v, 32'h0);
    rd(R_ER, v); chk("R10 input underrun", v, 32'h10);
  endtask

  task automatic t_err;
    wr(R_SWR, 1);
    for (int i = 0; i < 8; i++) wr(R_OF, 32'(i));
    rd(R_OP, v); chk("R9 out full and not empty", v, 32'h50);
    wr(R_OF, 32'hEE);
    rd(R_ER, v); chk("R10 output overrun", v, 32'h20);
    chk("R10 irq masked", 32'(err_irq), 0);
    wr(R_EE, 32'h20); chk("R10 irq enabled", 32'(err_irq), 1);
    wr(R_ER, 32'h20); chk("R10 w1c irq", 32'(err_irq), 0);
    rd(R_ER, v); chk("R10 w1c flag", v, 32'h0);
    set_state(2'd0);
    rd(R_OP, v); chk("R11 reset flushes", v, 32'h0);
  endtask

  task automatic t_pause;
    wr(R_SWR, 1); wr(R_CFG, 32'h87); wr(R_OC, 2);
    set_state(2'd1);
    wr(R_OF, 32'h5A); wr(R_OF, 32'h5B);
    set_state(2'd3);
    tx_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 tx held in pause", 32'(tx_valid), 0);
    tx_ready = 1'b0;
    rd(R_OP, v); chk("R13 fifo kept", v, 32'h110);
    set_state(2'd1);
    collect(2);
    chk("R13 resume byte0", 32'(cap[0]), 32'h5A);
    chk("R13 resume byte1", 32'(cap[1]), 32'h5B);
  endtask

  task automatic t_swrst;
    wr(R_SWR, 1); wr(R_CFG, 32'h87); wr(R_OC, 1);
    set_state(2'd1);
    tx_ready = 1'b1;
    repeat (2) @(negedge clk);
    tx_ready = 1'b0;
    rd(R_ER, v); chk("R10 output underrun", v, 32'h08);
    wr(R_CFG, 32'h13); wr(R_SWR, 1);
    rd(R_CFG, v); chk("R12 cfg restored", v, 32'h07);
    rd(R_ER, v);  chk("R12 errors cleared", v, 32'h0);
    rd(R_ST, v);  chk("R12 state reset", v, 32'h4);
    rd(R_OC, v);  chk("R12 count cleared", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_state();
    t_counts();
    t_tx();
    t_rx();
    t_err();
    t_pause();
    t_swrst();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule